// File: doc/BRIEF.md
# Pause Quanta Countdown Timer

This block keeps the pause-time count used for full-duplex flow control on an Ethernet-style MAC. A frame recognizer upstream hands it a one-cycle pulse together with the pause time carried in a valid pause frame. In full-duplex operation that time is written into a 16-bit countdown register. The register then counts down once per 512 bit times, which is 128 receive nibble-clock ticks. While the receive-pause option is on and the count is non-zero, a hold output tells the transmit engine not to start a new frame.

The countdown is gated differently depending on the pause option. With the option on, the count (and its prescaler) only advance while the transmitter reports idle. With it off, the count runs whether or not the transmitter is busy. A test setting makes every nibble tick decrement the count directly. Two maskable, single-cycle interrupt pulses are produced: one for every valid pause frame seen (in either duplex mode), and one when the count reaches zero by decrement.

Top module: `pause_hold_timer`

## Requirements
- R1: After reset, `pause_value` is 0 and `tx_hold`, `irq_pause_rx` and `irq_pause_zero` are all 0.
- R2: When `pause_valid` is high and `cfg_full_duplex` is 1 at a clock edge, `pause_value` equals `pause_time` from the next cycle. This holds whatever the previous count and whatever `cfg_pause_en` is.
- R3: When `cfg_full_duplex` is 0, a `pause_valid` pulse leaves `pause_value` unchanged.
- R4: `irq_pause_rx` is high for exactly the one cycle after each `pause_valid` pulse taken while `mask_pause_rx` is 0, in either duplex mode. It stays low while `mask_pause_rx` is 1.
- R5: `tx_hold` is 1 exactly when `cfg_pause_en` is 1, `cfg_full_duplex` is 1 and `pause_value` is non-zero.
- R6: With `cfg_fast_test` at 0, the count drops by one on the 128th counted `nibble_tick` after the last load.
- R7: With `cfg_fast_test` at 1, every counted `nibble_tick` drops the count by one.
- R8: With `cfg_pause_en` at 1, ticks taken while `tx_idle` is 0 neither decrement the count nor advance the prescaler. With `cfg_pause_en` at 0, ticks are counted regardless of `tx_idle`.
- R9: `irq_pause_zero` is high for the one cycle in which `pause_value` first reads 0 after a decrement from 1, provided `mask_pause_zero` is 0. It stays low when that mask is 1.
- R10: A load clears the prescaler. A load that falls in the same cycle as a due decrement wins: the new time is stored and no zero interrupt is raised.
- R11: At a count of 0, ticks leave `pause_value` at 0 (no wrap) and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nibble_tick | input | 1 | One-cycle enable per receive nibble-clock period |
| pause_valid | input | 1 | Valid pause frame received (one-cycle pulse) |
| pause_time | input | 16 | Pause time carried by that frame |
| cfg_pause_en | input | 1 | Receive-pause option: honour pause by holding transmit |
| cfg_full_duplex | input | 1 | 1 = full-duplex, 0 = half-duplex |
| cfg_fast_test | input | 1 | Decrement on every counted tick |
| tx_idle | input | 1 | Transmitter has stopped sending |
| mask_pause_rx | input | 1 | 1 masks the pause-received interrupt |
| mask_pause_zero | input | 1 | 1 masks the pause-zero interrupt |
| tx_hold | output | 1 | Do not start a new transmit frame |
| pause_value | output | 16 | Current countdown value |
| irq_pause_rx | output | 1 | Pause-received interrupt pulse |
| irq_pause_zero | output | 1 | Pause-count-reached-zero interrupt pulse |

## Verification
A fresh pause frame can arrive in the very cycle the count is due to step from 1 to 0, so the load and the terminal decrement compete for the register. The bench provokes this in test mode by loading a count of 1 and then raising `pause_valid` together with a tick. It expects the new time in the register, a pause-received pulse, and no zero pulse. A second bench case reloads the count midway through a prescaler period and then counts exactly 127 and 128 further ticks. This shows that the reload discarded the partial period rather than merging with it.

// File: rtl/pht_pkg.sv
package pht_pkg;

   // configuration bundle seen by the countdown logic
   typedef struct packed {
      logic pause_en;
      logic full_duplex;
      logic fast_test;
   } pht_cfg_t;

   // interrupt source indices
   localparam int unsigned IRQ_RX   = 0;
   localparam int unsigned IRQ_ZERO = 1;
   localparam int unsigned IRQ_N    = 2;

   // counting is allowed when the count is live and the gate condition holds
   function automatic logic count_gate(input pht_cfg_t cfg,
                                       input logic     idle,
                                       input logic     nonzero);
      return nonzero && (!cfg.pause_en || idle);
   endfunction

endpackage

// File: rtl/pht_prescale.sv
module pht_prescale #(
   parameter int unsigned PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   input  logic fast,
   output logic strobe
);

   localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

   generate
      if (PRESCALE == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, clear, fast};
         assign strobe = advance;
      end else begin : g_count
         logic [PS_W-1:0] cnt_q;
         logic            wrap;

         assign wrap   = (cnt_q == PS_LAST);
         assign strobe = advance && (fast || wrap);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear || fast) begin
               cnt_q <= '0;
            end else if (advance) begin
               cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pht_counter.sv
module pht_counter #(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              dec,
   output logic [TIME_W-1:0] value,
   output logic              nonzero,
   output logic              hit_zero
);

   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   logic [TIME_W-1:0] val_q;

   assign value    = val_q;
   assign nonzero  = (val_q != '0);
   // decrement from one to zero that is not overridden by a load
   assign hit_zero = dec && !load && (val_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (load) begin
         val_q <= load_val;
      end else if (dec && nonzero) begin
         val_q <= val_q - ONE;
      end
   end

endmodule

// File: rtl/pht_irq.sv
module pht_irq #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] mask,
   output logic [N-1:0] irq
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_src
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= evt[i] && !mask[i];
         end
         assign irq[i] = irq_q;
      end
   endgenerate

endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer
   import pht_pkg::*;
#(
   parameter int unsigned TIME_W   = 16,
   parameter int unsigned PRESCALE = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nibble_tick,
   input  logic              pause_valid,
   input  logic [TIME_W-1:0] pause_time,
   input  logic              cfg_pause_en,
   input  logic              cfg_full_duplex,
   input  logic              cfg_fast_test,
   input  logic              tx_idle,
   input  logic              mask_pause_rx,
   input  logic              mask_pause_zero,
   output logic              tx_hold,
   output logic [TIME_W-1:0] pause_value,
   output logic              irq_pause_rx,
   output logic              irq_pause_zero
);

   // elaboration-time parameter checks
   generate
      if (TIME_W < 2) begin : g_bad_width
         $error("pause_hold_timer: TIME_W must be at least 2");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("pause_hold_timer: PRESCALE must be at least 1");
      end
   endgenerate

   pht_cfg_t     cfg;
   logic         do_load;
   logic         live;
   logic         advance;
   logic         dec_strobe;
   logic         zero_evt;
   logic [IRQ_N-1:0] evt_vec;
   logic [IRQ_N-1:0] mask_vec;
   logic [IRQ_N-1:0] irq_vec;

   assign cfg.pause_en    = cfg_pause_en;
   assign cfg.full_duplex = cfg_full_duplex;
   assign cfg.fast_test   = cfg_fast_test;

   // a pause frame only reloads the count in full-duplex operation
   assign do_load = pause_valid && cfg.full_duplex;
   assign advance = nibble_tick && !do_load && count_gate(cfg, tx_idle, live);

   pht_prescale #(.PRESCALE(PRESCALE)) u_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (do_load),
      .advance(advance),
      .fast   (cfg.fast_test),
      .strobe (dec_strobe)
   );

   pht_counter #(.TIME_W(TIME_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (do_load),
      .load_val(pause_time),
      .dec     (dec_strobe),
      .value   (pause_value),
      .nonzero (live),
      .hit_zero(zero_evt)
   );

   assign evt_vec[IRQ_RX]    = pause_valid;
   assign evt_vec[IRQ_ZERO]  = zero_evt;
   assign mask_vec[IRQ_RX]   = mask_pause_rx;
   assign mask_vec[IRQ_ZERO] = mask_pause_zero;

   pht_irq #(.N(IRQ_N)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt_vec),
      .mask (mask_vec),
      .irq  (irq_vec)
   );

   assign irq_pause_rx   = irq_vec[IRQ_RX];
   assign irq_pause_zero = irq_vec[IRQ_ZERO];
   assign tx_hold        = cfg.pause_en && cfg.full_duplex && live;

endmodule

// File: rtl/pause_hold_timer_chk.sv
module pause_hold_timer_chk #(
   parameter int unsigned TIME_W   = 16,
   parameter int unsigned PRESCALE = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nibble_tick,
   input logic              pause_valid,
   input logic [TIME_W-1:0] pause_time,
   input logic              cfg_pause_en,
   input logic              cfg_full_duplex,
   input logic              cfg_fast_test,
   input logic              tx_idle,
   input logic              mask_pause_rx,
   input logic              mask_pause_zero,
   input logic              tx_hold,
   input logic [TIME_W-1:0] pause_value,
   input logic              irq_pause_rx,
   input logic              irq_pause_zero
);

   logic unused_chk;
   assign unused_chk = ^{mask_pause_zero, PRESCALE[0]};

   // R2
   load_takes_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_valid && cfg_full_duplex) |=> (pause_value == $past(pause_time)));

   // R3
   no_rise_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pause_valid && cfg_full_duplex) |=> (pause_value <= $past(pause_value)));

   // R4
   rx_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_valid && !mask_pause_rx) |=> irq_pause_rx);

   // R4
   rx_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pause_valid && !mask_pause_rx) |=> !irq_pause_rx);

   // R5
   half_duplex_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_full_duplex |-> !tx_hold);

   // R7
   fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fast_test && nibble_tick && !pause_valid && pause_value != '0
       && (!cfg_pause_en || tx_idle)) |=> (pause_value == $past(pause_value) - 1'b1));

   // R8
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pause_en && !tx_idle && !pause_valid) |=> $stable(pause_value));

   // R9
   zero_irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pause_zero |-> (pause_value == '0 && $past(pause_value) == TIME_W'(1)));

   // R11
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_value == '0 && !pause_valid) |=> (pause_value == '0 && !irq_pause_zero));

endmodule

bind pause_hold_timer pause_hold_timer_chk #(.TIME_W(TIME_W), .PRESCALE(PRESCALE)) u_chk (.*);

// File: tb/pause_hold_timer_tb.sv
`timescale 1ns/1ps
module pause_hold_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nibble_tick = 1'b0;
   logic        pause_valid = 1'b0;
   logic [15:0] pause_time = '0;
   logic        cfg_pause_en = 1'b0;
   logic        cfg_full_duplex = 1'b1;
   logic        cfg_fast_test = 1'b0;
   logic        tx_idle = 1'b1;
   logic        mask_pause_rx = 1'b0;
   logic        mask_pause_zero = 1'b0;
   logic        tx_hold;
   logic [15:0] pause_value;
   logic        irq_pause_rx;
   logic        irq_pause_zero;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   pause_hold_timer u_dut (
      .clk(clk), .rst_n(rst_n), .nibble_tick(nibble_tick),
      .pause_valid(pause_valid), .pause_time(pause_time),
      .cfg_pause_en(cfg_pause_en), .cfg_full_duplex(cfg_full_duplex),
      .cfg_fast_test(cfg_fast_test), .tx_idle(tx_idle),
      .mask_pause_rx(mask_pause_rx), .mask_pause_zero(mask_pause_zero),
      .tx_hold(tx_hold), .pause_value(pause_value),
      .irq_pause_rx(irq_pause_rx), .irq_pause_zero(irq_pause_zero)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one-cycle pause frame; called at a negedge, returns one negedge later
   task automatic send_pause(input logic [15:0] t);
      pause_time  = t;
      pause_valid = 1'b1;
      step(1);
      pause_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 value", pause_value, 0);
      chk("R1 hold", tx_hold, 0);
      chk("R1 irq_rx", irq_pause_rx, 0);
      chk("R1 irq_zero", irq_pause_zero, 0);
   endtask

   task automatic t_load_fd;
      cfg_full_duplex = 1; cfg_pause_en = 0; nibble_tick = 0;
      send_pause(16'h1234);
      chk("R2 load pause off", pause_value, 16'h1234);
      chk("R4 irq_rx fd", irq_pause_rx, 1);
      chk("R5 hold off when pause disabled", tx_hold, 0);
      step(1);
      chk("R4 irq_rx single cycle", irq_pause_rx, 0);
      send_pause(16'h00A5);
      chk("R2 overwrite", pause_value, 16'h00A5);
      cfg_pause_en = 1;
      step(1);
      chk("R5 hold on", tx_hold, 1);
   endtask

   task automatic t_half_duplex;
      cfg_full_duplex = 0;
      step(1);
      chk("R5 hold off in half duplex", tx_hold, 0);
      send_pause(16'h0777);
      chk("R3 value unchanged", pause_value, 16'h00A5);
      chk("R4 irq_rx half duplex", irq_pause_rx, 1);
      mask_pause_rx = 1;
      send_pause(16'h0888);
      chk("R4 irq_rx masked", irq_pause_rx, 0);
      mask_pause_rx = 0;
      cfg_full_duplex = 1;
      step(1);
   endtask

   task automatic t_fast_zero;
      cfg_pause_en = 0; cfg_fast_test = 1; nibble_tick = 0;
      send_pause(16'd4);
      nibble_tick = 1;
      step(1); chk("R7 fast 3", pause_value, 3);
      step(1); chk("R7 fast 2", pause_value, 2);
      step(1); chk("R7 fast 1", pause_value, 1);
      chk("R9 no early zero irq", irq_pause_zero, 0);
      step(1); chk("R7 fast 0", pause_value, 0);
      chk("R9 zero irq", irq_pause_zero, 1);
      step(1);
      chk("R11 stays zero", pause_value, 0);
      chk("R11 no repeat irq", irq_pause_zero, 0);
      step(3);
      chk("R11 still zero", pause_value, 0);
      nibble_tick = 0;
   endtask

   task automatic t_gate_fast;
      cfg_fast_test = 1; cfg_pause_en = 1; tx_idle = 0; nibble_tick = 0;
      send_pause(16'd10);
      nibble_tick = 1;
      step(4);
      chk("R8 busy blocks count", pause_value, 10);
      tx_idle = 1;
      step(2);
      chk("R8 idle counts", pause_value, 8);
      cfg_pause_en = 0; tx_idle = 0;
      step(3);
      chk("R8 pause off counts while busy", pause_value, 5);
      nibble_tick = 0; tx_idle = 1;
      mask_pause_zero = 1;
      send_pause(16'd1);
      nibble_tick = 1;
      step(1);
      chk("R9 masked reach zero", pause_value, 0);
      chk("R9 masked zero irq", irq_pause_zero, 0);
      nibble_tick = 0; mask_pause_zero = 0;
   endtask

   task automatic t_prescale;
      cfg_fast_test = 0; cfg_pause_en = 0; nibble_tick = 0;
      send_pause(16'd3);
      nibble_tick = 1;
      step(127);
      chk("R6 before 128th tick", pause_value, 3);
      step(1);
      chk("R6 at 128th tick", pause_value, 2);
      nibble_tick = 0;
   endtask

   task automatic t_prescale_gate;
      cfg_fast_test = 0; cfg_pause_en = 1; tx_idle = 1; nibble_tick = 0;
      send_pause(16'd2);
      nibble_tick = 1;
      step(100);
      tx_idle = 0;
      step(50);
      chk("R8 busy holds prescaler", pause_value, 2);
      chk("R5 hold while counting", tx_hold, 1);
      tx_idle = 1;
      step(27);
      chk("R8 prescaler resumed 127", pause_value, 2);
      step(1);
      chk("R8 prescaler resumed 128", pause_value, 1);
      nibble_tick = 0; cfg_pause_en = 0;
   endtask

   task automatic t_reload_prescale;
      cfg_fast_test = 0; cfg_pause_en = 0; nibble_tick = 0;
      send_pause(16'd5);
      nibble_tick = 1;
      step(100);
      chk("R10 mid period", pause_value, 5);
      send_pause(16'd5);
      step(127);
      chk("R10 prescaler cleared 127", pause_value, 5);
      step(1);
      chk("R10 prescaler cleared 128", pause_value, 4);
      nibble_tick = 0;
   endtask

   task automatic t_collision;
      cfg_fast_test = 1; cfg_pause_en = 0; nibble_tick = 0;
      send_pause(16'd1);
      nibble_tick = 1;
      send_pause(16'd9);
      nibble_tick = 0;
      chk("R10 load wins", pause_value, 9);
      chk("R10 no zero irq", irq_pause_zero, 0);
      chk("R4 irq_rx on collision", irq_pause_rx, 1);
      cfg_fast_test = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      step(3);
      t_reset;
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_load_fd;
      t_half_duplex;
      t_fast_zero;
      t_gate_fast;
      t_prescale;
      t_prescale_gate;
      t_reload_prescale;
      t_collision;
      step(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule